// File: doc/BRIEF.md
# Block-Scaled Low-Precision Integer Dot Product

This block forms the dot product of one quantization block of 128 low-precision unsigned weights with 128 half-precision activations, working only in integer arithmetic. Each weight is offset by a small per-block zero point. Each activation is turned into a signed integer mantissa aligned to an exponent shared by the whole block. The block's signed integer sum is returned together with the shared exponent and the block's half-precision scale. A later stage combines these three values into the final floating-point result.

Elements stream in over a valid/ready handshake. The scale, zero point and weight width are taken with the first element of a block. The block buffers the 128 elements while it tracks the largest exponent. It then replays them through a single multiply-accumulate lane and holds off new input until the result has been produced.

Top module: `qdot_block_unit`

## Requirements
- R1: A block is exactly 128 accepted elements, and `last_i` is high on the 128th accepted element only. An element is accepted on a rising edge where both `in_valid_i` and `in_ready_o` are high. `in_ready_o` is high whenever the unit is collecting.
- R2: `exp_o` reports the shared exponent, which is the largest 5-bit exponent field (`act[14:10]`) among the block's activations. It is 0 when every activation is zero or subnormal.
- R3: Each activation becomes the 11-bit mantissa `{1, act[9:0]}`, shifted right and truncated by (shared exponent − own exponent), then negated when `act[15]` is 1. Activations with an exponent field of 0 contribute 0.
- R4: With `mode_i`=0 (4-bit weights), each product is (`wgt_i[3:0]` − `zp_i[1:0]`) × aligned activation, with both operands taken as unsigned before the subtraction.
- R5: With `mode_i`=1 (2-bit weights), each product is (`wgt_i[1:0]` − `zp_i[0]`) × aligned activation. `wgt_i[3:2]` and `zp_i[1]` have no effect on the result.
- R6: `scale_i`, `zp_i` and `mode_i` are sampled only with the first element of a block. Their values during the other 127 elements have no effect, and `scale_o` returns the sampled scale.
- R7: `sum_o` is the exact signed 24-bit sum of the block's 128 products. It does not overflow, including when all 128 products are at the largest magnitude of either sign (±3,930,240).
- R8: `out_valid_o` is a one-cycle pulse raised by the 128th rising edge after the edge that accepts `last_i`. `sum_o`, `exp_o` and `scale_o` hold their values until the next pulse.
- R9: From the edge that accepts `last_i` until the result pulse, `in_ready_o` is low and input is ignored. The next block starts from a cleared sum.
- R10: While `rst_ni` is low, `in_ready_o` is 1, `out_valid_o` is 0, and `sum_o`, `exp_o` and `scale_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Element valid |
| in_ready_o | output | 1 | Unit can accept an element |
| wgt_i | input | 4 | Unsigned quantized weight |
| act_i | input | 16 | Half-precision activation |
| last_i | input | 1 | Marks the 128th element of a block |
| scale_i | input | 16 | Block scale, half precision |
| zp_i | input | 2 | Block zero point |
| mode_i | input | 1 | 0: 4-bit weights, 1: 2-bit weights |
| out_valid_o | output | 1 | Result pulse |
| sum_o | output | 24 | Signed integer block sum |
| exp_o | output | 5 | Shared exponent field |
| scale_o | output | 16 | Scale of the reported block |

## Verification
Saturated blocks push every product to its largest positive or largest negative value, which exposes accumulator width and sign handling. Fully random blocks in each weight mode exercise the zero-point subtraction. In the 2-bit blocks the unused weight and zero-point bits are filled with noise, so any leak of those bits into the result shows up. A block with one dominant exponent among small, zero and subnormal values tests truncation of deep shifts. An all-zero block tests the exponent floor. Narrow exponent spreads test one- and two-bit alignment. Noise is applied to the per-block fields after the first element and to the data inputs while the unit is busy, so the results also show whether sampling and back-pressure keep that noise out.

// File: rtl/qdot_pkg.sv
package qdot_pkg;
  localparam int FP_W    = 16;
  localparam int EXP_W   = 5;
  localparam int FRAC_W  = 10;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int WGT_W   = 4;
  localparam int ZP_W    = 2;
  localparam int WQ_W    = WGT_W + 1;
  localparam int ACT_I_W = MANT_W + 1;
  localparam int PROD_W  = WQ_W + ACT_I_W;

  typedef enum logic {WM_INT4 = 1'b0, WM_INT2 = 1'b1} wmode_e;
  typedef enum logic {ST_FILL = 1'b0, ST_RUN = 1'b1} st_e;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
  } fp_unp_t;
endpackage

// File: rtl/qdot_fp_unpack.sv
module qdot_fp_unpack
  import qdot_pkg::*;
(
  input  logic [FP_W-1:0] fp_i,
  output fp_unp_t         unp_o
);
  logic [EXP_W-1:0] e;
  assign e = fp_i[FP_W-2 -: EXP_W];

  always_comb begin
    unp_o.sign = fp_i[FP_W-1];
    unp_o.expo = e;
    // zero and subnormal collapse to zero
    unp_o.mant = (e == '0) ? '0 : {1'b1, fp_i[FRAC_W-1:0]};
  end
endmodule

// File: rtl/qdot_buf.sv
module qdot_buf #(
  parameter int DEPTH  = 128,
  parameter int WORD_W = 20,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/qdot_mac.sv
module qdot_mac
  import qdot_pkg::*;
#(
  parameter int IDX_W  = 7,
  localparam int ACC_W = PROD_W + IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             first_i,
  input  logic [WGT_W-1:0] wgt_i,
  input  logic [ZP_W-1:0]  zp_i,
  input  wmode_e           mode_i,
  input  fp_unp_t          act_i,
  input  logic [EXP_W-1:0] emax_i,
  output logic [ACC_W-1:0] acc_next_o
);
  logic [EXP_W-1:0]          shamt;
  logic [MANT_W-1:0]         mag;
  logic signed [ACT_I_W-1:0] act_s;
  logic signed [WQ_W-1:0]    wq;
  logic signed [PROD_W-1:0]  prod;
  logic signed [ACC_W-1:0]   acc_q, base;
  logic signed [ACC_W:0]     sum_w;

  assign shamt = emax_i - act_i.expo;
  assign mag   = act_i.mant >> shamt;
  assign act_s = act_i.sign ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  always_comb begin
    if (mode_i == WM_INT2)
      wq = $signed({3'b000, wgt_i[1:0]}) - $signed({4'b0000, zp_i[0]});
    else
      wq = $signed({1'b0, wgt_i}) - $signed({3'b000, zp_i});
  end

  assign prod  = wq * act_s;
  assign base  = first_i ? '0 : acc_q;
  assign sum_w = (ACC_W+1)'(base) + (ACC_W+1)'(prod);
  assign acc_next_o = sum_w[ACC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_w[ACC_W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (sum_w[ACC_W] == sum_w[ACC_W-1])); // R7
endmodule

// File: rtl/qdot_block_unit.sv
module qdot_block_unit
  import qdot_pkg::*;
#(
  parameter int BLK_LEN = 128,
  localparam int IDX_W  = $clog2(BLK_LEN),
  localparam int ACC_W  = PROD_W + IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WGT_W-1:0] wgt_i,
  input  logic [FP_W-1:0]  act_i,
  input  logic             last_i,
  input  logic [FP_W-1:0]  scale_i,
  input  logic [ZP_W-1:0]  zp_i,
  input  logic             mode_i,
  output logic             out_valid_o,
  output logic [ACC_W-1:0] sum_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [FP_W-1:0]  scale_o
);
  localparam int WORD_W = WGT_W + FP_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_LEN - 1);

  st_e               state_q;
  logic [IDX_W-1:0]  wr_idx_q, rd_idx_q;
  logic [EXP_W-1:0]  emax_q, in_exp;
  logic [FP_W-1:0]   scale_q;
  logic [ZP_W-1:0]   zp_q;
  wmode_e            mode_q;
  logic              accept, run, first_el;
  logic [WORD_W-1:0] rd_word;
  fp_unp_t           rd_unp;
  logic [ACC_W-1:0]  acc_next;

  assign in_ready_o = (state_q == ST_FILL);
  assign accept     = in_valid_i & in_ready_o;
  assign run        = (state_q == ST_RUN);
  assign first_el   = (wr_idx_q == '0);
  assign in_exp     = act_i[FP_W-2 -: EXP_W];

  qdot_buf #(.DEPTH(BLK_LEN), .WORD_W(WORD_W)) u_buf (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (wr_idx_q),
    .wdata_i ({wgt_i, act_i}),
    .raddr_i (rd_idx_q),
    .rdata_o (rd_word)
  );

  qdot_fp_unpack u_unp (
    .fp_i  (rd_word[FP_W-1:0]),
    .unp_o (rd_unp)
  );

  qdot_mac #(.IDX_W(IDX_W)) u_mac (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (run),
    .first_i    (rd_idx_q == '0),
    .wgt_i      (rd_word[WORD_W-1 -: WGT_W]),
    .zp_i       (zp_q),
    .mode_i     (mode_q),
    .act_i      (rd_unp),
    .emax_i     (emax_q),
    .acc_next_o (acc_next)
  );

  // block parameters and running exponent maximum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emax_q  <= '0;
      scale_q <= '0;
      zp_q    <= '0;
      mode_q  <= WM_INT4;
    end else if (accept) begin
      if (first_el) begin
        emax_q  <= in_exp;
        scale_q <= scale_i;
        zp_q    <= zp_i;
        mode_q  <= wmode_e'(mode_i);
      end else if (in_exp > emax_q) begin
        emax_q  <= in_exp;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_FILL;
      wr_idx_q    <= '0;
      rd_idx_q    <= '0;
      out_valid_o <= 1'b0;
      sum_o       <= '0;
      exp_o       <= '0;
      scale_o     <= '0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (state_q)
        ST_FILL: if (accept) begin
          if (last_i) begin
            state_q  <= ST_RUN;
            wr_idx_q <= '0;
            rd_idx_q <= '0;
          end else begin
            wr_idx_q <= wr_idx_q + 1'b1;
          end
        end
        ST_RUN: begin
          rd_idx_q <= rd_idx_q + 1'b1;
          if (rd_idx_q == LAST_IDX) begin
            state_q     <= ST_FILL;
            out_valid_o <= 1'b1;
            sum_o       <= acc_next;
            exp_o       <= emax_q;
            scale_o     <= scale_q;
          end
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  AST_LAST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && last_i) |-> (wr_idx_q == LAST_IDX)); // R1
  AST_FULL_NEEDS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && wr_idx_q == LAST_IDX) |-> last_i); // R1
  AST_EXP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (emax_q >= $past(in_exp))); // R2
  AST_OUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(sum_o) && $stable(exp_o) && $stable(scale_o))); // R8
  AST_BUSY_BEFORE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$past(in_ready_o)); // R9
endmodule

// File: tb/tb_qdot_block_unit.sv
`timescale 1ns/1ps
module tb_qdot_block_unit;
  localparam int BLK   = 128;
  localparam int ACC_W = qdot_pkg::PROD_W + $clog2(BLK);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [3:0]       wgt_i = '0;
  logic [15:0]      act_i = '0;
  logic             last_i = 1'b0;
  logic [15:0]      scale_i = '0;
  logic [1:0]       zp_i = '0;
  logic             mode_i = 1'b0;
  logic             out_valid_o;
  logic [ACC_W-1:0] sum_o;
  logic [4:0]       exp_o;
  logic [15:0]      scale_o;

  int vec = 0;
  int err = 0;

  logic [3:0]  w_arr [BLK];
  logic [15:0] a_arr [BLK];

  always #4 clk_i = ~clk_i;

  qdot_block_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .wgt_i(wgt_i), .act_i(act_i), .last_i(last_i), .scale_i(scale_i), .zp_i(zp_i),
    .mode_i(mode_i), .out_valid_o(out_valid_o), .sum_o(sum_o), .exp_o(exp_o),
    .scale_o(scale_o)
  );

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    vec++;
    if (got != exp) begin
      err++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
  endtask

  initial begin
    #(8 * 100000);
    err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  function automatic logic [15:0] mk_act(input int pat, input int i);
    logic [4:0] e;
    case (pat)
      0: return {1'b0, 5'd30, 10'h3FF};
      1: return {1'b1, 5'd30, 10'h3FF};
      4: begin
        e = (i == 5) ? 5'd30 : 5'(($urandom % 21));
        return {1'($urandom), e, 10'($urandom)};
      end
      5: return {1'($urandom), 5'd0, 10'($urandom)};
      6: return {1'($urandom), 5'(14 + ($urandom % 3)), 10'($urandom)};
      default: return {1'($urandom), 5'(1 + ($urandom % 30)), 10'($urandom)};
    endcase
  endfunction

  task automatic run_block(input int b);
    int          pat;
    string       tag;
    logic        m;
    logic [1:0]  zp;
    logic [15:0] sc;
    int          emax, e, mag, a, wq, n, rdy_bad;
    longint      sum_exp, held;
    pat = b % 7;
    case (pat)
      0, 1: tag = "R7";
      2:    tag = "R4";
      3:    tag = "R5";
      5:    tag = "R2";
      default: tag = "R3";
    endcase
    m  = (pat == 3) ? 1'b1 : (pat == 6) ? 1'(b) : 1'b0;
    zp = (pat <= 1) ? 2'd0 : 2'($urandom);
    sc = 16'($urandom);
    for (int i = 0; i < BLK; i++) begin
      w_arr[i] = (pat <= 1) ? 4'hF : 4'($urandom);
      a_arr[i] = mk_act(pat, i);
    end
    // model
    emax = 0;
    for (int i = 0; i < BLK; i++) begin
      e = int'(a_arr[i][14:10]);
      if (e > emax) emax = e;
    end
    sum_exp = 0;
    for (int i = 0; i < BLK; i++) begin
      e = int'(a_arr[i][14:10]);
      if (e == 0) a = 0;
      else begin
        mag = (1024 + int'(a_arr[i][9:0])) >>> (emax - e);
        a = a_arr[i][15] ? -mag : mag;
      end
      wq = m ? (int'(w_arr[i][1:0]) - int'(zp[0])) : (int'(w_arr[i]) - int'(zp));
      sum_exp += longint'(wq * a);
    end
    // drive; per-block fields are noise after element 0 (R6)
    for (int i = 0; i < BLK; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      wgt_i  = w_arr[i];
      act_i  = a_arr[i];
      last_i = (i == BLK - 1);
      if (i == 0) begin scale_i = sc; zp_i = zp; mode_i = m; end
      else begin scale_i = 16'($urandom); zp_i = 2'($urandom); mode_i = 1'($urandom); end
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    // busy: noise on every input (R9)
    n = 0;
    rdy_bad = 0;
    forever begin
      @(negedge clk_i);
      n++;
      if (out_valid_o) begin
        in_valid_i = 1'b0;
        last_i = 1'b0;
        break;
      end
      if (in_ready_o) rdy_bad++;
      wgt_i = 4'($urandom); act_i = 16'($urandom); last_i = 1'($urandom);
      scale_i = 16'($urandom); zp_i = 2'($urandom); mode_i = 1'($urandom);
      if (n > 400) break;
    end
    chk("R8", "latency edges", n - 1, BLK);
    chk("R9", "ready high while busy", rdy_bad, 0);
    chk(tag, "sum (R6/R9 noise ignored)", $signed(sum_o), sum_exp);
    chk("R2", "shared exponent", exp_o, emax);
    chk("R6", "scale", scale_o, sc);
    held = $signed(sum_o);
    @(negedge clk_i);
    chk("R8", "valid pulse width", out_valid_o, 0);
    chk("R8", "sum held", $signed(sum_o), held);
    chk("R1", "ready after result", in_ready_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10", "reset ready", in_ready_o, 1);
    chk("R10", "reset valid", out_valid_o, 0);
    chk("R10", "reset sum", sum_o, 0);
    chk("R10", "reset exp/scale", {exp_o, scale_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "ready idle", in_ready_o, 1);
    for (int b = 0; b < 14; b++) run_block(b);
    summary();
    $finish;
  end
endmodule